// File: doc/BRIEF.md
# Interrupt Controller Configuration Register Interface

This block is the byte-wide programming front end of an eight-input interrupt controller. Software reaches it through two addresses. Address 0 takes the opening word of an initialization sequence and two classes of run-time command. Address 1 takes the later initialization words and, once the sequence has finished, the interrupt mask. The block tracks the initialization step and holds the resulting configuration: vector base, single/cascade choice, automatic end-of-interrupt, special fully nested mode, rotate on automatic end-of-interrupt and special mask. Priority commands go to the arbitration core as single-cycle strobes.

On the read side the block selects among the mask, the core's request vector and the core's in-service vector. A poll armed earlier takes over the next read, which returns the core's poll word instead. The arbitration and priority resolution live in a separate core, so this block only decodes, sequences and multiplexes.

Top module: `irq_cfg_regif`

## Requirements
- R1: A write to address 0 with data bit 4 set pulses `init_clr` in that cycle and clears mask, vector base, read select, poll, special mask, rotate, auto end-of-interrupt and special fully nested mode. It records bit 0 as "fourth word expected" and bit 1 as `single_mode`, and puts `init_step` at 1. Step encoding: 0 idle, 1 vector word, 2 cascade word, 3 fourth word.
- R2: `level_err` equals bit 3 of the most recent opening word, which flags a request for level-triggered inputs.
- R3: At step 1, a write to address 1 sets `vec_base` to data bits 7:3 with bits 2:0 forced to zero.
- R4: After the vector word the step becomes 2 when cascaded. When single it becomes 3 if a fourth word is expected, and 0 otherwise.
- R5: At step 2, a write to address 1 changes neither the mask nor any configuration output. The step becomes 3 if a fourth word is expected, or 0 if not.
- R6: At step 3, a write to address 1 sets `sfn_mode` from data bit 4 and `auto_eoi` from data bit 1, and returns the step to 0.
- R7: A write to address 0 with bit 4 clear and bit 3 set is a read/poll command. Bit 2 arms a poll. Bit 0 loads the read select only when bit 1 is set, and bit 5 loads `spec_mask` only when bit 6 is set.
- R8: A write to address 0 with bits 4 and 3 clear is a priority command whose code is bits 7:5 and whose level is bits 2:0. Codes 0 and 4 set `rot_aeoi` to code bit 2 and produce no strobe. Every other code pulses `prio_cmd_stb` in the write cycle, with `prio_cmd_code` and `prio_cmd_lvl` valid.
- R9: At step 0, a write to address 1 loads the mask and pulses `mask_load`. A read of address 1 returns the mask.
- R10: With no poll pending, a read of address 0 returns `svc_vec` when read select is 1 and `req_vec` when it is 0.
- R11: With a poll pending, the next read at either address returns `poll_word`, pulses `poll_ack` and clears the poll. A poll armed by a command in the same cycle as that read stays armed for the following read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 1 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| req_vec | input | 8 | Request vector from the core |
| svc_vec | input | 8 | In-service vector from the core |
| poll_word | input | 8 | Poll result from the core |
| rdata | output | 8 | Read data, valid while rd_en is high |
| init_clr | output | 1 | Pulse: core state clear on an opening word |
| mask_load | output | 1 | Pulse: mask written |
| mask_q | output | 8 | Current mask |
| prio_cmd_stb | output | 1 | Pulse: priority command |
| prio_cmd_code | output | 3 | Priority command code |
| prio_cmd_lvl | output | 3 | Priority command level |
| poll_ack | output | 1 | Pulse: poll result consumed |
| vec_base | output | 8 | Vector base |
| single_mode | output | 1 | Single controller, no cascade |
| auto_eoi | output | 1 | Automatic end-of-interrupt |
| sfn_mode | output | 1 | Special fully nested mode |
| rot_aeoi | output | 1 | Rotate on automatic end-of-interrupt |
| spec_mask | output | 1 | Special mask mode |
| level_err | output | 1 | Level-triggered request seen |
| init_step | output | 2 | Initialization step |

## Verification
The poll consumption and a poll-arming command can fall in the same cycle. The bench provokes this by holding a read and a read/poll command with bit 2 set on address 0 in one clock, with a poll already pending. It judges the outcome by the data: that read must return the poll word with `poll_ack` high, and the next read must again return the poll word, because the new arming wins over the clear. A third read then shows the request vector, proving the flag finally cleared.

// File: rtl/irq_cfg_pkg.sv
package irq_cfg_pkg;
   typedef enum logic [1:0] {
      STEP_IDLE = 2'd0,
      STEP_VEC  = 2'd1,
      STEP_CAS  = 2'd2,
      STEP_W4   = 2'd3
   } init_step_e;

   typedef enum logic [1:0] {
      CMD_NONE = 2'd0,
      CMD_INIT = 2'd1,
      CMD_CTRL = 2'd2,
      CMD_PRIO = 2'd3
   } cmd0_e;

   typedef struct packed {
      logic sfn;
      logic aeoi;
      logic single;
      logic expect4;
      logic lvl_err;
   } init_cfg_t;
endpackage

// File: rtl/irq_cfg_wdec.sv
module irq_cfg_wdec
   import irq_cfg_pkg::*;
(
   input  logic  wr_en,
   input  logic  addr,
   input  logic  b4,
   input  logic  b3,
   output cmd0_e kind0,
   output logic  wr1
);
   always_comb begin
      kind0 = CMD_NONE;
      if (wr_en && !addr) begin
         if (b4)      kind0 = CMD_INIT;
         else if (b3) kind0 = CMD_CTRL;
         else         kind0 = CMD_PRIO;
      end
   end

   assign wr1 = wr_en && addr;
endmodule

// File: rtl/irq_cfg_initseq.sv
module irq_cfg_initseq
   import irq_cfg_pkg::*;
#(
   parameter int IRQ_N = 8,
   localparam int LVL_W = $clog2(IRQ_N)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  cmd0_e                  kind0,
   input  logic                   wr1,
   input  logic [IRQ_N-1:LVL_W]   vec_in,
   input  logic                   b4,
   input  logic                   b3,
   input  logic                   b1,
   input  logic                   b0,
   output init_step_e             step,
   output init_cfg_t              cfg,
   output logic [IRQ_N-1:0]       vec_base,
   output logic                   init_clr
);
   assign init_clr = (kind0 == CMD_INIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step     <= STEP_IDLE;
         cfg      <= '0;
         vec_base <= '0;
      end else if (init_clr) begin
         step        <= STEP_VEC;
         cfg         <= '0;
         cfg.expect4 <= b0;
         cfg.single  <= b1;
         cfg.lvl_err <= b3;
         vec_base    <= '0;
      end else if (wr1) begin
         unique case (step)
            STEP_VEC: begin
               vec_base <= {vec_in, {LVL_W{1'b0}}};
               if (!cfg.single)     step <= STEP_CAS;
               else if (cfg.expect4) step <= STEP_W4;
               else                 step <= STEP_IDLE;
            end
            STEP_CAS: step <= cfg.expect4 ? STEP_W4 : STEP_IDLE;
            STEP_W4: begin
               cfg.sfn  <= b4;
               cfg.aeoi <= b1;
               step     <= STEP_IDLE;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/irq_cfg_opregs.sv
module irq_cfg_opregs
   import irq_cfg_pkg::*;
#(
   parameter int IRQ_N     = 8,
   parameter int RDATA_REG = 0,
   localparam int LVL_W    = $clog2(IRQ_N)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  cmd0_e              kind0,
   input  logic               wr1,
   input  init_step_e         step,
   input  logic [IRQ_N-1:0]   wdata,
   input  logic               rd_en,
   input  logic               addr,
   input  logic [IRQ_N-1:0]   req_vec,
   input  logic [IRQ_N-1:0]   svc_vec,
   input  logic [IRQ_N-1:0]   poll_word,
   output logic [IRQ_N-1:0]   mask_q,
   output logic               mask_load,
   output logic               rot_aeoi,
   output logic               spec_mask,
   output logic               prio_cmd_stb,
   output logic [2:0]         prio_cmd_code,
   output logic [LVL_W-1:0]   prio_cmd_lvl,
   output logic               poll_ack,
   output logic [IRQ_N-1:0]   rdata
);
   logic             rd_sel_q;
   logic             poll_q;
   logic [IRQ_N-1:0] rd_word;
   logic             rot_cmd;

   assign mask_load     = wr1 && (step == STEP_IDLE);
   assign rot_cmd       = (kind0 == CMD_PRIO) && (wdata[6:5] == 2'b00);
   assign prio_cmd_stb  = (kind0 == CMD_PRIO) && !rot_cmd;
   assign prio_cmd_code = wdata[7:5];
   assign prio_cmd_lvl  = wdata[LVL_W-1:0];
   assign poll_ack      = rd_en && poll_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q    <= '0;
         rd_sel_q  <= 1'b0;
         poll_q    <= 1'b0;
         spec_mask <= 1'b0;
         rot_aeoi  <= 1'b0;
      end else if (kind0 == CMD_INIT) begin
         mask_q    <= '0;
         rd_sel_q  <= 1'b0;
         poll_q    <= 1'b0;
         spec_mask <= 1'b0;
         rot_aeoi  <= 1'b0;
      end else begin
         if (mask_load) mask_q <= wdata;
         if (poll_ack)  poll_q <= 1'b0;
         if (kind0 == CMD_CTRL) begin
            if (wdata[2]) poll_q    <= 1'b1;
            if (wdata[1]) rd_sel_q  <= wdata[0];
            if (wdata[6]) spec_mask <= wdata[5];
         end
         if (rot_cmd) rot_aeoi <= wdata[7];
      end
   end

   always_comb begin
      if (poll_q)      rd_word = poll_word;
      else if (addr)   rd_word = mask_q;
      else if (rd_sel_q) rd_word = svc_vec;
      else             rd_word = req_vec;
   end

   generate
      if (RDATA_REG == 0) begin : g_rd_comb
         assign rdata = rd_en ? rd_word : '0;
      end else begin : g_rd_reg
         logic [IRQ_N-1:0] rdata_q;
         always_ff @(posedge clk) begin
            if (!rst_n)     rdata_q <= '0;
            else if (rd_en) rdata_q <= rd_word;
         end
         assign rdata = rdata_q;
      end
   endgenerate
endmodule

// File: rtl/irq_cfg_regif.sv
module irq_cfg_regif
   import irq_cfg_pkg::*;
#(
   parameter int IRQ_N     = 8,
   parameter int RDATA_REG = 0,
   localparam int LVL_W    = $clog2(IRQ_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [IRQ_N-1:0]  wdata,
   input  logic [IRQ_N-1:0]  req_vec,
   input  logic [IRQ_N-1:0]  svc_vec,
   input  logic [IRQ_N-1:0]  poll_word,
   output logic [IRQ_N-1:0]  rdata,
   output logic              init_clr,
   output logic              mask_load,
   output logic [IRQ_N-1:0]  mask_q,
   output logic              prio_cmd_stb,
   output logic [2:0]        prio_cmd_code,
   output logic [LVL_W-1:0]  prio_cmd_lvl,
   output logic              poll_ack,
   output logic [IRQ_N-1:0]  vec_base,
   output logic              single_mode,
   output logic              auto_eoi,
   output logic              sfn_mode,
   output logic              rot_aeoi,
   output logic              spec_mask,
   output logic              level_err,
   output logic [1:0]        init_step
);
   generate
      if (IRQ_N != 8) begin : g_bad_width
         $error("irq_cfg_regif: command field positions require IRQ_N == 8");
      end
      if (RDATA_REG != 0 && RDATA_REG != 1) begin : g_bad_rdreg
         $error("irq_cfg_regif: RDATA_REG must be 0 or 1");
      end
   endgenerate

   cmd0_e      kind0;
   logic       wr1;
   init_step_e step;
   init_cfg_t  cfg;

   irq_cfg_wdec u_wdec (
      .wr_en (wr_en),
      .addr  (addr),
      .b4    (wdata[4]),
      .b3    (wdata[3]),
      .kind0 (kind0),
      .wr1   (wr1)
   );

   irq_cfg_initseq #(.IRQ_N(IRQ_N)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .kind0    (kind0),
      .wr1      (wr1),
      .vec_in   (wdata[IRQ_N-1:LVL_W]),
      .b4       (wdata[4]),
      .b3       (wdata[3]),
      .b1       (wdata[1]),
      .b0       (wdata[0]),
      .step     (step),
      .cfg      (cfg),
      .vec_base (vec_base),
      .init_clr (init_clr)
   );

   irq_cfg_opregs #(.IRQ_N(IRQ_N), .RDATA_REG(RDATA_REG)) u_ops (
      .clk           (clk),
      .rst_n         (rst_n),
      .kind0         (kind0),
      .wr1           (wr1),
      .step          (step),
      .wdata         (wdata),
      .rd_en         (rd_en),
      .addr          (addr),
      .req_vec       (req_vec),
      .svc_vec       (svc_vec),
      .poll_word     (poll_word),
      .mask_q        (mask_q),
      .mask_load     (mask_load),
      .rot_aeoi      (rot_aeoi),
      .spec_mask     (spec_mask),
      .prio_cmd_stb  (prio_cmd_stb),
      .prio_cmd_code (prio_cmd_code),
      .prio_cmd_lvl  (prio_cmd_lvl),
      .poll_ack      (poll_ack),
      .rdata         (rdata)
   );

   assign single_mode = cfg.single;
   assign auto_eoi    = cfg.aeoi;
   assign sfn_mode    = cfg.sfn;
   assign level_err   = cfg.lvl_err;
   assign init_step   = step;
endmodule

// File: rtl/irq_cfg_regif_chk.sv
module irq_cfg_regif_chk #(
   parameter int IRQ_N     = 8,
   parameter int RDATA_REG = 0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             addr,
   input logic             wr_en,
   input logic             rd_en,
   input logic [IRQ_N-1:0] wdata,
   input logic [IRQ_N-1:0] poll_word,
   input logic [IRQ_N-1:0] rdata,
   input logic             init_clr,
   input logic             mask_load,
   input logic [IRQ_N-1:0] mask_q,
   input logic             prio_cmd_stb,
   input logic             poll_ack,
   input logic [IRQ_N-1:0] vec_base,
   input logic             rot_aeoi,
   input logic             level_err,
   input logic [1:0]       init_step
);
   logic open_wr, data_wr, prio_wr;
   assign open_wr = wr_en && !addr && wdata[4];
   assign data_wr = wr_en && addr;
   assign prio_wr = wr_en && !addr && !wdata[4] && !wdata[3];

   assert_open_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      open_wr |=> (init_step == 2'd1 && mask_q == '0));

   assert_level_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      open_wr |=> (level_err == $past(wdata[3])));

   assert_vec_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && init_step == 2'd1) |=>
         (vec_base == {$past(wdata[IRQ_N-1:3]), 3'b000}));

   assert_cas_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && init_step == 2'd2) |=>
         ((init_step == 2'd3 || init_step == 2'd0) && $stable(mask_q)));

   assert_rot_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (prio_wr && wdata[6:5] == 2'b00) |=> (rot_aeoi == $past(wdata[7])));

   assert_mask_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && init_step == 2'd0) |=> (mask_q == $past(wdata)));

   assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({init_clr, mask_load, prio_cmd_stb}));

   generate
      if (RDATA_REG == 0) begin : g_poll_comb
         assert_poll_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
            poll_ack |-> (rd_en && rdata == poll_word));
      end else begin : g_poll_reg
         assert_poll_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
            poll_ack |=> (rdata == $past(poll_word)));
      end
   endgenerate
endmodule

bind irq_cfg_regif irq_cfg_regif_chk #(.IRQ_N(IRQ_N), .RDATA_REG(RDATA_REG)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .addr         (addr),
   .wr_en        (wr_en),
   .rd_en        (rd_en),
   .wdata        (wdata),
   .poll_word    (poll_word),
   .rdata        (rdata),
   .init_clr     (init_clr),
   .mask_load    (mask_load),
   .mask_q       (mask_q),
   .prio_cmd_stb (prio_cmd_stb),
   .poll_ack     (poll_ack),
   .vec_base     (vec_base),
   .rot_aeoi     (rot_aeoi),
   .level_err    (level_err),
   .init_step    (init_step)
);

// File: tb/irq_cfg_regif_tb.sv
`timescale 1ns/1ps
module irq_cfg_regif_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       addr = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] req_vec = '0;
   logic [7:0] svc_vec = '0;
   logic [7:0] poll_word = '0;
   logic [7:0] rdata;
   logic       init_clr, mask_load, prio_cmd_stb, poll_ack;
   logic [7:0] mask_q, vec_base;
   logic [2:0] prio_cmd_code, prio_cmd_lvl;
   logic       single_mode, auto_eoi, sfn_mode, rot_aeoi, spec_mask, level_err;
   logic [1:0] init_step;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   irq_cfg_regif u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .req_vec(req_vec), .svc_vec(svc_vec), .poll_word(poll_word),
      .rdata(rdata), .init_clr(init_clr), .mask_load(mask_load), .mask_q(mask_q),
      .prio_cmd_stb(prio_cmd_stb), .prio_cmd_code(prio_cmd_code),
      .prio_cmd_lvl(prio_cmd_lvl), .poll_ack(poll_ack), .vec_base(vec_base),
      .single_mode(single_mode), .auto_eoi(auto_eoi), .sfn_mode(sfn_mode),
      .rot_aeoi(rot_aeoi), .spec_mask(spec_mask), .level_err(level_err),
      .init_step(init_step)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // write; strobes sampled inside the write cycle
   logic s_init, s_mload, s_prio;
   logic [2:0] s_code, s_lvl;
   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      #1;
      s_init = init_clr; s_mload = mask_load; s_prio = prio_cmd_stb;
      s_code = prio_cmd_code; s_lvl = prio_cmd_lvl;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   logic [7:0] r_val;
   logic       r_ack;
   task automatic rd(input logic a);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1;
      r_val = rdata; r_ack = poll_ack;
      @(posedge clk); #1;
      rd_en = 1'b0;
   endtask

   task automatic rdwr(input logic a, input logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1; wr_en = 1'b1; wdata = d;
      #1;
      r_val = rdata; r_ack = poll_ack;
      @(posedge clk); #1;
      rd_en = 1'b0; wr_en = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 reset step", {6'd0, init_step}, 8'h00);
      chk("R1 reset cfg", {2'b0, single_mode, auto_eoi, sfn_mode, rot_aeoi, spec_mask, level_err}, 8'h00);
      rd(1'b1);
      chk("R9 reset mask read", r_val, 8'h00);
   endtask

   task automatic t_init_cascade();
      wr(1'b1, 8'hA5);
      chk("R9 mask_load pulse", {7'd0, s_mload}, 8'h01);
      rd(1'b1);
      chk("R9 mask read", r_val, 8'hA5);
      wr(1'b0, 8'h11);
      chk("R1 init_clr pulse", {7'd0, s_init}, 8'h01);
      chk("R1 step after open", {6'd0, init_step}, 8'h01);
      chk("R1 mask cleared", mask_q, 8'h00);
      chk("R1 single bit", {7'd0, single_mode}, 8'h00);
      chk("R2 no level flag", {7'd0, level_err}, 8'h00);
      wr(1'b1, 8'h6D);
      chk("R3 vector base", vec_base, 8'h68);
      chk("R4 cascaded goes to step 2", {6'd0, init_step}, 8'h02);
      chk("R9 no mask load during init", {7'd0, s_mload}, 8'h00);
      wr(1'b1, 8'h04);
      chk("R5 cascade to step 3", {6'd0, init_step}, 8'h03);
      chk("R5 mask untouched", mask_q, 8'h00);
      chk("R5 config untouched", {5'd0, sfn_mode, auto_eoi, single_mode}, 8'h00);
      wr(1'b1, 8'h12);
      chk("R6 sfn and aeoi", {6'd0, sfn_mode, auto_eoi}, 8'h03);
      chk("R6 back to idle", {6'd0, init_step}, 8'h00);
   endtask

   task automatic t_init_single();
      wr(1'b0, 8'h1A);
      chk("R2 level flag set", {7'd0, level_err}, 8'h01);
      chk("R1 single set", {7'd0, single_mode}, 8'h01);
      chk("R1 modes cleared", {6'd0, sfn_mode, auto_eoi}, 8'h00);
      wr(1'b1, 8'hFF);
      chk("R3 vector low bits zero", vec_base, 8'hF8);
      chk("R4 single no fourth to idle", {6'd0, init_step}, 8'h00);
      wr(1'b1, 8'h3C);
      chk("R9 mask load idle", mask_q, 8'h3C);
      wr(1'b0, 8'h13);
      chk("R2 level flag cleared", {7'd0, level_err}, 8'h00);
      wr(1'b1, 8'h08);
      chk("R4 single with fourth to step 3", {6'd0, init_step}, 8'h03);
      wr(1'b1, 8'h00);
      chk("R6 fourth word zero", {6'd0, sfn_mode, auto_eoi}, 8'h00);
      chk("R6 idle", {6'd0, init_step}, 8'h00);
   endtask

   task automatic t_readsel();
      req_vec = 8'h81; svc_vec = 8'h42;
      rd(1'b0);
      chk("R10 default reads request", r_val, 8'h81);
      wr(1'b0, 8'h0B);
      rd(1'b0);
      chk("R10 select in-service", r_val, 8'h42);
      wr(1'b0, 8'h0A);
      rd(1'b0);
      chk("R10 select request", r_val, 8'h81);
      wr(1'b0, 8'h09);
      rd(1'b0);
      chk("R7 select ignored without bit 1", r_val, 8'h81);
      wr(1'b0, 8'h68);
      chk("R7 special mask set", {7'd0, spec_mask}, 8'h01);
      wr(1'b0, 8'h08);
      chk("R7 special mask held without bit 6", {7'd0, spec_mask}, 8'h01);
      wr(1'b0, 8'h48);
      chk("R7 special mask cleared", {7'd0, spec_mask}, 8'h00);
   endtask

   task automatic t_prio();
      wr(1'b0, 8'h80);
      chk("R8 code 4 sets rotate", {7'd0, rot_aeoi}, 8'h01);
      chk("R8 code 4 no strobe", {7'd0, s_prio}, 8'h00);
      wr(1'b0, 8'h00);
      chk("R8 code 0 clears rotate", {7'd0, rot_aeoi}, 8'h00);
      chk("R8 code 0 no strobe", {7'd0, s_prio}, 8'h00);
      wr(1'b0, 8'h65);
      chk("R8 code 3 strobe", {7'd0, s_prio}, 8'h01);
      chk("R8 code 3 fields", {s_code, 2'b0, s_lvl}, {3'd3, 2'b0, 3'd5});
      wr(1'b0, 8'h80);
      wr(1'b0, 8'hE2);
      chk("R8 code 7 strobe", {s_code, 1'b0, s_prio, 1'b0, s_lvl}, {3'd7, 1'b0, 1'b1, 1'b0, 3'd2});
      chk("R8 code 7 keeps rotate", {7'd0, rot_aeoi}, 8'h01);
   endtask

   task automatic t_poll();
      poll_word = 8'h83;
      wr(1'b1, 8'h5A);
      wr(1'b0, 8'h0C);
      rd(1'b1);
      chk("R11 poll read data", r_val, 8'h83);
      chk("R11 poll ack", {7'd0, r_ack}, 8'h01);
      rd(1'b1);
      chk("R11 poll cleared, mask read", r_val, 8'h5A);
      chk("R11 no ack after clear", {7'd0, r_ack}, 8'h00);
      wr(1'b0, 8'h0C);
      rdwr(1'b0, 8'h0C);
      chk("R11 same-cycle read gets poll", r_val, 8'h83);
      chk("R11 same-cycle ack", {7'd0, r_ack}, 8'h01);
      rd(1'b0);
      chk("R11 rearm wins over clear", r_val, 8'h83);
      rd(1'b0);
      chk("R10 request after poll", r_val, 8'h81);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_init_cascade();
      t_init_single();
      t_readsel();
      t_prio();
      t_poll();
      done = 1'b1;
      summary();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
      end
   end
endmodule